// File: doc/BRIEF.md
# Bit-Serial Clock and Battery RAM Slave

This block sits behind two software-driven lines: a serial clock and a data bit, both set by the host writing a control byte. Each transaction takes sixteen falling edges of the serial clock. The first eight edges carry a command byte, most significant bit first. The next eight edges form the data phase. In that phase the host shifts in a value and the block shifts a result byte out on a separate data-out line.

A read command returns one of three things: a byte of the 32-byte battery RAM, a BCD time field taken from an external time bus, or one of two internal bytes, status and control. A write command stores the shifted value either into RAM or into the control byte. A control write with the acknowledge bit set clears two status flags and sends a one-cycle interrupt-clear pulse. The block does not keep time itself; it only reports the BCD fields presented on its time input.

Top module: `serial_rtc_slave`

## Requirements
- R1: After reset the status byte is 0x90, the control byte is 0x00, every RAM byte is 0x00, sdata_out is 0 and irq_clear is 0. The bit counter starts at the first command bit.
- R2: Bits are taken only in the clk cycle where sclk_in was 1 in the previous cycle and is 0 now (a falling edge). Rising edges, steady levels and sdata_in changes while the clock line is held still have no effect.
- R3: Edges 1 to 8 shift in the command MSB first. On data-phase edges 9 to 16, sdata_out carries bits 7 down to 0 of the selected read byte, one bit per edge, valid from the cycle after each edge until the next edge.
- R4: Commands 0x00 to 0x1F read the RAM byte at the address given by the command.
- R5: Commands 0x20 to 0x25 read time_bcd[7:0] (seconds), [15:8] (minutes), [23:16] (hours), [31:24] (day), [39:32] (month) and [47:40] (year minus 2000), in that order. Commands 0x26 to 0x2F read 0x00.
- R6: Command 0x30 reads the status byte and command 0x31 reads the control byte.
- R7: On the 16th edge, commands 0x80 to 0x9F store the eight data-phase bits (MSB first) into RAM at address command minus 0x80.
- R8: On the 16th edge, command 0xB1 stores the data-phase value into the control byte. If bit 2 of that value is 1, it also clears status bits 4 and 3 and drives irq_clear high for exactly one clk cycle.
- R9: Any other command returns 0x00 in the data phase and changes neither the RAM, the status byte nor the control byte.
- R10: Asserting abort returns the bit counter to the first command bit, so the next falling edge begins a new command.
- R11: After the 16th edge the counter wraps to the first command bit, so transactions can follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock line level as written by the host |
| sdata_in | input | 1 | Serial data line level as written by the host |
| abort | input | 1 | Returns the bit counter to the command start |
| time_bcd | input | 48 | BCD time fields: year, month, day, hour, minute, second from the top byte down |
| sdata_out | output | 1 | Serial result bit for the data phase |
| irq_clear | output | 1 | One-cycle pulse that acknowledges the clock interrupt |

## Verification
Byte patterns such as 0xA5 and 0x3C are written and then read back. A reversed shift order, or a data-phase index that is one edge off, would garble these patterns or land them at the wrong address. The data line is toggled while the clock is held low, so a design that samples on levels or on rising edges would take in wrong bits. The edges of each range are probed: 0x1F and 0x9F, the last time field, the first unmapped time code, and an unused write code. An off-by-one decoder would leak RAM data or write where it should not. The acknowledge path is checked with bit 2 clear and then set, which catches a pulse that fires on every control write or that lasts two cycles. An abort in the middle of a command catches a counter that keeps its count.

// File: rtl/serial_rtc_slave.sv
module serial_rtc_slave #(
  parameter int          RAM_WORDS   = 32,
  parameter int          TIME_FIELDS = 6,
  parameter logic [7:0]  STATUS_INIT = 8'h90,
  parameter logic [7:0]  RD_TIME     = 8'h20,
  parameter logic [7:0]  RD_STATUS   = 8'h30,
  parameter logic [7:0]  RD_CONTROL  = 8'h31,
  parameter logic [7:0]  WR_RAM      = 8'h80,
  parameter logic [7:0]  WR_CONTROL  = 8'hB1,
  parameter int          ACK_BIT     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk_in,
  input  logic                    sdata_in,
  input  logic                    abort,
  input  logic [8*TIME_FIELDS-1:0] time_bcd,
  output logic                    sdata_out,
  output logic                    irq_clear
);
  localparam int AW = $clog2(RAM_WORDS);
  localparam logic [7:0] ACK_FLAGS = 8'h18;

  logic       sclk_q;
  logic [3:0] phase;
  logic [7:0] cmd;
  logic [6:0] val;
  logic [7:0] status, control;
  logic [7:0] ram [RAM_WORDS];
  logic [7:0] tfield, rd_byte, nv;

  wire fall    = sclk_q & ~sclk_in;
  wire is_rram = cmd < 8'(RAM_WORDS);
  wire is_time = (cmd >= RD_TIME) && (cmd < RD_TIME + 8'(TIME_FIELDS));
  wire is_wram = (cmd >= WR_RAM) && (cmd < WR_RAM + 8'(RAM_WORDS));
  wire [7:0] tidx = cmd - RD_TIME;
  wire [7:0] widx = cmd - WR_RAM;

  assign nv = {val, sdata_in};

  always_comb begin
    tfield = '0;
    for (int i = 0; i < TIME_FIELDS; i++)
      if (tidx == 8'(i)) tfield = time_bcd[8*i +: 8];
  end

  always_comb begin
    rd_byte = '0;
    if (is_rram)                rd_byte = ram[cmd[AW-1:0]];
    else if (is_time)           rd_byte = tfield;
    else if (cmd == RD_STATUS)  rd_byte = status;
    else if (cmd == RD_CONTROL) rd_byte = control;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      phase     <= '0;
      cmd       <= '0;
      val       <= '0;
      sdata_out <= 1'b0;
      status    <= STATUS_INIT;
      control   <= '0;
      irq_clear <= 1'b0;
      for (int i = 0; i < RAM_WORDS; i++) ram[i] <= '0;
    end else begin
      sclk_q    <= sclk_in;
      irq_clear <= 1'b0;
      if (abort) begin
        phase <= '0;
      end else if (fall) begin
        phase <= phase + 4'd1;
        if (!phase[3]) begin
          cmd       <= {cmd[6:0], sdata_in};
          sdata_out <= 1'b0;
        end else begin
          val       <= nv[6:0];
          sdata_out <= rd_byte[~phase[2:0]];
          if (phase == 4'd15) begin
            if (is_wram) ram[widx[AW-1:0]] <= nv;
            if (cmd == WR_CONTROL) begin
              control <= nv;
              if (nv[ACK_BIT]) begin
                status    <= status & ~ACK_FLAGS;
                irq_clear <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  // R10
  abort_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> phase == 4'd0);

  // R2
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdata_out) && $stable(cmd));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |-> cmd == WR_CONTROL && phase == 4'd0 && (status & ACK_FLAGS) == 8'h00);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> !irq_clear);

  // R9
  status_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(status[7:5]) && $stable(status[2:0]));

  // R5
  time_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= 4'd9 && cmd >= RD_TIME + 8'(TIME_FIELDS) && cmd < RD_STATUS) |-> !sdata_out);
endmodule

// File: tb/test_serial_rtc_slave.sv
module test_serial_rtc_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic        abort = 1'b0;
  logic [47:0] time_bcd = {8'h24, 8'h12, 8'h31, 8'h23, 8'h59, 8'h45};
  logic        sdata_out, irq_clear;

  int applied = 0;
  int miscomp = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_rtc_slave i_serial_rtc_slave (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .abort(abort), .time_bcd(time_bcd), .sdata_out(sdata_out), .irq_clear(irq_clear)
  );

  // {requirement, command, write value, expected read byte, expected irq pulse}
  localparam int NV = 31;
  localparam logic [28:0] VEC [NV] = '{
    {4'd6,  8'h30, 8'h00, 8'h90, 1'b0},  // R6 R1 status reset value
    {4'd6,  8'h31, 8'h00, 8'h00, 1'b0},  // R6 R1 control reset value
    {4'd1,  8'h05, 8'h00, 8'h00, 1'b0},  // R1 RAM cleared
    {4'd7,  8'h85, 8'hA5, 8'h00, 1'b0},  // R7 write RAM 5
    {4'd4,  8'h05, 8'h00, 8'hA5, 1'b0},  // R4 R3 read back, bit order
    {4'd7,  8'h9F, 8'h3C, 8'h00, 1'b0},  // R7 top RAM write
    {4'd4,  8'h1F, 8'hFF, 8'h3C, 1'b0},  // R4 top RAM read
    {4'd7,  8'h80, 8'h5A, 8'h00, 1'b0},  // R7 bottom RAM write
    {4'd4,  8'h00, 8'h00, 8'h5A, 1'b0},  // R4 bottom RAM read
    {4'd4,  8'h04, 8'h00, 8'h00, 1'b0},  // R4 neighbour untouched
    {4'd5,  8'h20, 8'h00, 8'h45, 1'b0},  // R5 seconds
    {4'd5,  8'h21, 8'h00, 8'h59, 1'b0},  // R5 minutes
    {4'd5,  8'h22, 8'h00, 8'h23, 1'b0},  // R5 hours
    {4'd5,  8'h23, 8'h00, 8'h31, 1'b0},  // R5 day
    {4'd5,  8'h24, 8'h00, 8'h12, 1'b0},  // R5 month
    {4'd5,  8'h25, 8'h00, 8'h24, 1'b0},  // R5 year
    {4'd5,  8'h26, 8'h00, 8'h00, 1'b0},  // R5 unmapped time code
    {4'd5,  8'h2F, 8'h00, 8'h00, 1'b0},  // R5 last time code
    {4'd9,  8'h40, 8'h00, 8'h00, 1'b0},  // R9 unknown read
    {4'd9,  8'hA0, 8'hFF, 8'h00, 1'b0},  // R9 unknown write
    {4'd9,  8'h00, 8'h00, 8'h5A, 1'b0},  // R9 RAM unchanged
    {4'd9,  8'h31, 8'h00, 8'h00, 1'b0},  // R9 control unchanged
    {4'd8,  8'hB1, 8'h00, 8'h00, 1'b0},  // R8 control write, no ack
    {4'd8,  8'h30, 8'h00, 8'h90, 1'b0},  // R8 status kept
    {4'd8,  8'hB1, 8'h04, 8'h00, 1'b1},  // R8 ack write
    {4'd8,  8'h30, 8'h00, 8'h80, 1'b0},  // R8 flags cleared
    {4'd8,  8'h31, 8'h00, 8'h04, 1'b0},  // R8 control stored
    {4'd8,  8'hB1, 8'h80, 8'h00, 1'b0},  // R8 no ack bit
    {4'd11, 8'h31, 8'h00, 8'h80, 1'b0},  // R11 back to back
    {4'd9,  8'hFF, 8'h00, 8'h00, 1'b0},  // R9 top command code
    {4'd11, 8'h30, 8'h00, 8'h80, 1'b0}   // R11 status still 0x80
  };

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic o, output logic ia, output logic ib, output logic steady);
    @(negedge clk) sdata_in = b; sclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk) sclk_in = 1'b0;
    @(negedge clk) o = sdata_out; ia = irq_clear; sdata_in = ~b;
    @(negedge clk) ib = irq_clear; steady = (sdata_out === o);
    sdata_in = b;
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] w, output logic [7:0] rd,
                      output logic pulse, output logic wide, output logic steady);
    logic o, ia, ib, st;
    pulse = 0; wide = 0; steady = 1; rd = '0;
    for (int k = 7; k >= 0; k--) begin
      send_bit(c[k], o, ia, ib, st);
      pulse |= ia;
    end
    for (int k = 7; k >= 0; k--) begin
      send_bit(w[k], o, ia, ib, st);
      rd[k] = o; steady &= st;
      pulse |= ia; wide |= ib;
    end
  endtask

  initial begin
    logic [7:0] rd;
    logic pulse, wide, steady, o, ia, ib, st;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    check(1, "sdata_out at reset", {7'd0, sdata_out}, 8'h00);
    check(1, "irq_clear at reset", {7'd0, irq_clear}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    // R2 rising edges and data toggles with the clock held high advance nothing
    @(negedge clk) sclk_in = 1'b1;
    repeat (4) @(negedge clk) sdata_in = ~sdata_in;
    @(negedge clk) sclk_in = 1'b0;
    // that one fall shifts a single bit; abort clears it (R10)
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][24:17], VEC[v][16:9], rd, pulse, wide, steady);
      check(int'(VEC[v][28:25]), $sformatf("cmd %02h read", VEC[v][24:17]), rd, VEC[v][8:1]);
      check(8, $sformatf("cmd %02h irq_clear", VEC[v][24:17]), {7'd0, pulse}, {7'd0, VEC[v][0]});
      if (wide) check(8, "irq_clear longer than one cycle", 8'h01, 8'h00);
      // R3 R2 output holds between edges despite data toggles
      if (!steady) check(3, "sdata_out changed without an edge", 8'h01, 8'h00);
    end

    // R10 abort in the middle of a command
    send_bit(1'b1, o, ia, ib, st);
    send_bit(1'b1, o, ia, ib, st);
    send_bit(1'b0, o, ia, ib, st);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    xfer(8'h31, 8'h00, rd, pulse, wide, steady);
    check(10, "read after abort", rd, 8'h80);

    // R11 immediate follow-up transaction
    xfer(8'h85, 8'h00, rd, pulse, wide, steady);
    xfer(8'h05, 8'h00, rd, pulse, wide, steady);
    check(11, "overwrite then read", rd, 8'h00);

    // R1 reset restores defaults mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    xfer(8'h30, 8'h00, rd, pulse, wide, steady);
    check(1, "status after second reset", rd, 8'h90);
    xfer(8'h1F, 8'h00, rd, pulse, wide, steady);
    check(1, "RAM after second reset", rd, 8'h00);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      applied++; miscomp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end
endmodule